// File: doc/BRIEF.md
# Circular Reorder Buffer with Tag Wakeup

This block keeps decoded instructions in program order in a circular array of entries. The index of an entry is its tag. Decode writes one instruction per cycle at the allocation pointer. Each source operand arrives either as a finished value or as the tag of the entry that will produce it. A waiting source watches the result broadcast. When a broadcast tag matches the waiting tag, the source field takes the broadcast value and the source becomes present. Any entry whose two sources are present may be sent to the functional units, whatever its program order. Only one entry goes per cycle, and the choice is the oldest ready entry counted from the commit pointer.

A broadcast whose tag names an issued entry completes that entry and stores its result and its exception cause. Commit reads only the entry at the commit pointer. When that entry is complete with a zero cause, it is written out to the architectural state and the pointer moves on by one. When it is complete with a non-zero cause, the buffer raises a flush, reports the cause and writes nothing. In the same cycle it empties the buffer by moving the allocation pointer back to the commit pointer.

Every entry runs its own four-state machine. The states are FREE, WAIT, ISSUED and DONE. The transitions are named allocate (FREE to WAIT), issue (WAIT to ISSUED), complete (ISSUED to DONE), retire (DONE to FREE) and flush (any state to FREE). Flush takes priority over every other transition. DEPTH must be a power of two.

Top module: `rob_wakeup_core`

## Requirements
- R1: After reset the buffer is empty: alloc_ready=1, alloc_tag=0, and disp_valid, commit_valid and flush_valid are all 0.
- R2: Each accepted allocation is given the tag alloc_tag, which is the low bits of the allocation pointer. Tags count up by one per allocation and wrap from DEPTH-1 to 0.
- R3: After DEPTH allocations with no commit, alloc_ready is 0. An alloc_valid in that state changes no entry and does not move the pointer.
- R4: An entry is offered on the dispatch port only while both of its sources are present. The port shows the entry's tag, opcode and two operand values. An accepted entry (disp_valid and disp_ready both 1) is never offered again.
- R5: When several entries are ready, the one offered is the oldest, counted from the commit pointer. At most one entry leaves per cycle.
- R6: A broadcast (bc_valid=1) replaces every waiting source that holds tag bc_tag with bc_data and marks it present. The entry can be offered from the next cycle on.
- R7: A broadcast in the same cycle as an allocation is also matched against the incoming sources of that allocation.
- R8: A broadcast to an issued entry completes it with bc_data and bc_cause. Commit is strictly in order, so a completed entry does not commit while an older entry is not complete.
- R9: When the entry at the commit pointer is complete with bc_cause equal to 0, commit_valid is 1 for one cycle with its destination, write enable and data. The commit pointer then advances by one.
- R10: When the entry at the commit pointer is complete with a non-zero cause, flush_valid=1, flush_cause shows that cause, commit_valid=0 and alloc_ready=0. In the next cycle the buffer is empty, nothing is offered for dispatch, and alloc_tag equals the faulting entry's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Decode presents an instruction |
| alloc_op | input | OP_W | Opcode |
| alloc_s1_rdy | input | 1 | Source 1 is a value (1) or a tag (0) |
| alloc_s1_val | input | DATA_W | Source 1 value, or producer tag in the low bits |
| alloc_s2_rdy | input | 1 | Source 2 is a value (1) or a tag (0) |
| alloc_s2_val | input | DATA_W | Source 2 value, or producer tag in the low bits |
| alloc_dst | input | REG_W | Destination register |
| alloc_dst_en | input | 1 | Instruction writes a register |
| alloc_ready | output | 1 | An allocation is accepted this cycle |
| alloc_tag | output | TAG_W | Tag given to the presented instruction |
| disp_valid | output | 1 | A ready entry is offered |
| disp_ready | input | 1 | Functional units accept the offer |
| disp_tag | output | TAG_W | Tag of the offered entry |
| disp_op | output | OP_W | Opcode of the offered entry |
| disp_a | output | DATA_W | Operand 1 value |
| disp_b | output | DATA_W | Operand 2 value |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Producer tag of the result |
| bc_data | input | DATA_W | Result value |
| bc_cause | input | CAUSE_W | Exception cause, 0 means none |
| commit_valid | output | 1 | Entry written to architectural state |
| commit_dst | output | REG_W | Destination register |
| commit_dst_en | output | 1 | Register write enable |
| commit_data | output | DATA_W | Result value |
| flush_valid | output | 1 | Faulting entry at the commit pointer, buffer emptied |
| flush_cause | output | CAUSE_W | Cause of the faulting entry |

## Verification
Two kinds of cycle get the most attention. The first is one where a broadcast, an allocation and a dispatch acceptance all occur together. The bench sets that up by sending the result for the one tag the incoming instruction waits on in the same cycle as the allocation. It judges the outcome by the operand value the new entry shows on the dispatch port one cycle later, and by the commit of the broadcast's producer. The second is a completion of a younger entry ahead of an older one. There the bench checks that commit_valid stays low until the older result arrives. It also checks that a faulting entry at the commit pointer turns a pending commit into a flush.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        ENT_FREE   = 2'd0,
        ENT_WAIT   = 2'd1,
        ENT_ISSUED = 2'd2,
        ENT_DONE   = 2'd3
    } ent_state_e;

endpackage

// File: rtl/rob_entry.sv
module rob_entry
    import rob_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int OP_W    = 6,
    parameter int REG_W   = 5,
    parameter int CAUSE_W = 4,
    parameter int TAG_W   = 3,
    parameter int MY_TAG  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [OP_W-1:0]    op_i,
    input  logic               s1_rdy_i,
    input  logic [DATA_W-1:0]  s1_val_i,
    input  logic               s2_rdy_i,
    input  logic [DATA_W-1:0]  s2_val_i,
    input  logic [REG_W-1:0]   dst_i,
    input  logic               dst_en_i,
    input  logic               bc_valid_i,
    input  logic [TAG_W-1:0]   bc_tag_i,
    input  logic [DATA_W-1:0]  bc_data_i,
    input  logic [CAUSE_W-1:0] bc_cause_i,
    input  logic               issue_i,
    input  logic               retire_i,
    input  logic               flush_i,
    output logic               ready_o,
    output logic               done_o,
    output ent_state_e         state_o,
    output logic [OP_W-1:0]    op_o,
    output logic [DATA_W-1:0]  a_o,
    output logic [DATA_W-1:0]  b_o,
    output logic [REG_W-1:0]   dst_o,
    output logic               dst_en_o,
    output logic [DATA_W-1:0]  data_o,
    output logic [CAUSE_W-1:0] cause_o
);

    localparam logic [TAG_W-1:0] SELF = TAG_W'(MY_TAG);

    ent_state_e          state_q, state_d;
    logic [OP_W-1:0]     op_q;
    logic                s1_rdy_q, s2_rdy_q;
    logic [DATA_W-1:0]   s1_q, s2_q;
    logic [REG_W-1:0]    dst_q;
    logic                dst_en_q;
    logic [DATA_W-1:0]   data_q;
    logic [CAUSE_W-1:0]  cause_q;

    logic in1_hit, in2_hit, w1_hit, w2_hit, self_hit;

    // wakeup matches for incoming and stored sources
    assign in1_hit  = bc_valid_i && !s1_rdy_i && (s1_val_i[TAG_W-1:0] == bc_tag_i);
    assign in2_hit  = bc_valid_i && !s2_rdy_i && (s2_val_i[TAG_W-1:0] == bc_tag_i);
    assign w1_hit   = bc_valid_i && (state_q == ENT_WAIT) && !s1_rdy_q && (s1_q[TAG_W-1:0] == bc_tag_i);
    assign w2_hit   = bc_valid_i && (state_q == ENT_WAIT) && !s2_rdy_q && (s2_q[TAG_W-1:0] == bc_tag_i);
    assign self_hit = bc_valid_i && (state_q == ENT_ISSUED) && (bc_tag_i == SELF);

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE:   if (load_i)   state_d = ENT_WAIT;    // allocate
            ENT_WAIT:   if (issue_i)  state_d = ENT_ISSUED;  // issue
            ENT_ISSUED: if (self_hit) state_d = ENT_DONE;    // complete
            ENT_DONE:   if (retire_i) state_d = ENT_FREE;    // retire
            default:                  state_d = ENT_FREE;
        endcase
        if (flush_i) state_d = ENT_FREE;                     // flush
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    // payload registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= '0;
            s1_rdy_q <= 1'b0;
            s2_rdy_q <= 1'b0;
            s1_q     <= '0;
            s2_q     <= '0;
            dst_q    <= '0;
            dst_en_q <= 1'b0;
            data_q   <= '0;
            cause_q  <= '0;
        end else if (load_i && !flush_i) begin
            op_q     <= op_i;
            s1_rdy_q <= s1_rdy_i | in1_hit;
            s1_q     <= in1_hit ? bc_data_i : s1_val_i;
            s2_rdy_q <= s2_rdy_i | in2_hit;
            s2_q     <= in2_hit ? bc_data_i : s2_val_i;
            dst_q    <= dst_i;
            dst_en_q <= dst_en_i;
            cause_q  <= '0;
        end else begin
            if (w1_hit) begin
                s1_rdy_q <= 1'b1;
                s1_q     <= bc_data_i;
            end
            if (w2_hit) begin
                s2_rdy_q <= 1'b1;
                s2_q     <= bc_data_i;
            end
            if (self_hit) begin
                data_q  <= bc_data_i;
                cause_q <= bc_cause_i;
            end
        end
    end

    // output process
    always_comb begin
        ready_o  = (state_q == ENT_WAIT) && s1_rdy_q && s2_rdy_q;
        done_o   = (state_q == ENT_DONE);
        state_o  = state_q;
        op_o     = op_q;
        a_o      = s1_q;
        b_o      = s2_q;
        dst_o    = dst_q;
        dst_en_o = dst_en_q;
        data_o   = data_q;
        cause_o  = cause_q;
    end

    p_issue_only_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> ready_o);

    p_load_into_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (state_q == ENT_FREE));

    p_retire_only_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |-> done_o);

    p_issue_leaves_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !flush_i) |=> (state_q == ENT_ISSUED));

endmodule

// File: rtl/rob_pick.sv
module rob_pick #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 3
) (
    input  logic [DEPTH-1:0] ready_i,
    input  logic [TAG_W-1:0] head_i,
    output logic             valid_o,
    output logic [TAG_W-1:0] idx_o
);

    // scan from the commit pointer forward; first ready entry is the oldest
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid_o && ready_i[head_i + TAG_W'(i)]) begin
                valid_o = 1'b1;
                idx_o   = head_i + TAG_W'(i);
            end
        end
    end

endmodule

// File: rtl/rob_wakeup_core.sv
module rob_wakeup_core
    import rob_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int DATA_W  = 32,
    parameter int OP_W    = 6,
    parameter int REG_W   = 5,
    parameter int CAUSE_W = 4,
    localparam int TAG_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [OP_W-1:0]    alloc_op,
    input  logic               alloc_s1_rdy,
    input  logic [DATA_W-1:0]  alloc_s1_val,
    input  logic               alloc_s2_rdy,
    input  logic [DATA_W-1:0]  alloc_s2_val,
    input  logic [REG_W-1:0]   alloc_dst,
    input  logic               alloc_dst_en,
    output logic               alloc_ready,
    output logic [TAG_W-1:0]   alloc_tag,
    output logic               disp_valid,
    input  logic               disp_ready,
    output logic [TAG_W-1:0]   disp_tag,
    output logic [OP_W-1:0]    disp_op,
    output logic [DATA_W-1:0]  disp_a,
    output logic [DATA_W-1:0]  disp_b,
    input  logic               bc_valid,
    input  logic [TAG_W-1:0]   bc_tag,
    input  logic [DATA_W-1:0]  bc_data,
    input  logic [CAUSE_W-1:0] bc_cause,
    output logic               commit_valid,
    output logic [REG_W-1:0]   commit_dst,
    output logic               commit_dst_en,
    output logic [DATA_W-1:0]  commit_data,
    output logic               flush_valid,
    output logic [CAUSE_W-1:0] flush_cause
);

    localparam int PTR_W = TAG_W + 1;

    logic [PTR_W-1:0] alloc_q, head_q;
    logic [TAG_W-1:0] alloc_idx, head_idx;
    logic             empty, full;

    logic [DEPTH-1:0]   ready_vec, done_vec;
    ent_state_e         ent_state [DEPTH];
    logic [OP_W-1:0]    op_arr    [DEPTH];
    logic [DATA_W-1:0]  a_arr     [DEPTH];
    logic [DATA_W-1:0]  b_arr     [DEPTH];
    logic [REG_W-1:0]   dst_arr   [DEPTH];
    logic [DEPTH-1:0]   dst_en_vec;
    logic [DATA_W-1:0]  data_arr  [DEPTH];
    logic [CAUSE_W-1:0] cause_arr [DEPTH];

    logic             pick_valid;
    logic [TAG_W-1:0] pick_idx;
    logic             head_done, head_fault, commit_fire, flush, alloc_fire, disp_fire;

    assign alloc_idx = alloc_q[TAG_W-1:0];
    assign head_idx  = head_q[TAG_W-1:0];
    assign empty     = (alloc_q == head_q);
    assign full      = (alloc_q[TAG_W] != head_q[TAG_W]) && (alloc_idx == head_idx);

    assign head_done   = !empty && done_vec[head_idx];
    assign head_fault  = head_done && (cause_arr[head_idx] != '0);
    assign commit_fire = head_done && !head_fault;
    assign flush       = head_fault;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign disp_fire   = disp_valid && disp_ready;

    rob_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
        .ready_i (ready_vec),
        .head_i  (head_idx),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        rob_entry #(
            .DATA_W(DATA_W), .OP_W(OP_W), .REG_W(REG_W),
            .CAUSE_W(CAUSE_W), .TAG_W(TAG_W), .MY_TAG(g)
        ) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (alloc_fire && (alloc_idx == TAG_W'(g))),
            .op_i       (alloc_op),
            .s1_rdy_i   (alloc_s1_rdy),
            .s1_val_i   (alloc_s1_val),
            .s2_rdy_i   (alloc_s2_rdy),
            .s2_val_i   (alloc_s2_val),
            .dst_i      (alloc_dst),
            .dst_en_i   (alloc_dst_en),
            .bc_valid_i (bc_valid),
            .bc_tag_i   (bc_tag),
            .bc_data_i  (bc_data),
            .bc_cause_i (bc_cause),
            .issue_i    (disp_fire && (pick_idx == TAG_W'(g))),
            .retire_i   (commit_fire && (head_idx == TAG_W'(g))),
            .flush_i    (flush),
            .ready_o    (ready_vec[g]),
            .done_o     (done_vec[g]),
            .state_o    (ent_state[g]),
            .op_o       (op_arr[g]),
            .a_o        (a_arr[g]),
            .b_o        (b_arr[g]),
            .dst_o      (dst_arr[g]),
            .dst_en_o   (dst_en_vec[g]),
            .data_o     (data_arr[g]),
            .cause_o    (cause_arr[g])
        );
    end

    // pointer register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_q <= '0;
            head_q  <= '0;
        end else if (flush) begin
            alloc_q <= head_q;
        end else begin
            if (alloc_fire)  alloc_q <= alloc_q + PTR_W'(1);
            if (commit_fire) head_q  <= head_q + PTR_W'(1);
        end
    end

    // output process
    always_comb begin
        alloc_ready   = !full && !flush;
        alloc_tag     = alloc_idx;
        disp_valid    = pick_valid && !flush;
        disp_tag      = pick_idx;
        disp_op       = op_arr[pick_idx];
        disp_a        = a_arr[pick_idx];
        disp_b        = b_arr[pick_idx];
        commit_valid  = commit_fire;
        commit_dst    = dst_arr[head_idx];
        commit_dst_en = dst_en_vec[head_idx];
        commit_data   = data_arr[head_idx];
        flush_valid   = flush;
        flush_cause   = cause_arr[head_idx];
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(alloc_q - head_q)) <= PTR_W'(DEPTH));

    p_disp_from_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid |-> (ent_state[disp_tag] == ENT_WAIT));

    p_commit_advances_r9: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> (head_q == $past(head_q) + PTR_W'(1)));

    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> (empty && (ready_vec == '0) && !commit_valid));

    p_commit_needs_head_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (ent_state[head_idx] == ENT_DONE));

endmodule

// File: tb/rob_wakeup_core_tb.sv
module rob_wakeup_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4, DATA_W = 16, OP_W = 4, REG_W = 5, CAUSE_W = 4;
    localparam int TAG_W = 2;

    // row: op(4) s1_rdy(1) s1_val(16) s2_rdy(1) s2_val(16) dst(5) exp_tag(2)
    localparam int ROW_W = 45;
    localparam logic [ROW_W-1:0] ALLOC_TBL [4] = '{
        {4'd1, 1'b1, 16'd10, 1'b1, 16'd20, 5'd1, 2'd0},
        {4'd2, 1'b0, 16'd0,  1'b1, 16'd5,  5'd2, 2'd1},
        {4'd3, 1'b1, 16'd7,  1'b1, 16'd8,  5'd3, 2'd2},
        {4'd4, 1'b0, 16'd2,  1'b0, 16'd0,  5'd4, 2'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0, alloc_s1_rdy = 0, alloc_s2_rdy = 0, alloc_dst_en = 0;
    logic [OP_W-1:0] alloc_op = '0;
    logic [DATA_W-1:0] alloc_s1_val = '0, alloc_s2_val = '0;
    logic [REG_W-1:0] alloc_dst = '0;
    logic alloc_ready, disp_valid, commit_valid, commit_dst_en, flush_valid;
    logic [TAG_W-1:0] alloc_tag, disp_tag;
    logic disp_ready = 0, bc_valid = 0;
    logic [TAG_W-1:0] bc_tag = '0;
    logic [DATA_W-1:0] bc_data = '0;
    logic [CAUSE_W-1:0] bc_cause = '0;
    logic [OP_W-1:0] disp_op;
    logic [DATA_W-1:0] disp_a, disp_b, commit_data;
    logic [REG_W-1:0] commit_dst;
    logic [CAUSE_W-1:0] flush_cause;

    int n_chk = 0, n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_wakeup_core #(.DEPTH(DEPTH), .DATA_W(DATA_W), .OP_W(OP_W),
                      .REG_W(REG_W), .CAUSE_W(CAUSE_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op),
        .alloc_s1_rdy(alloc_s1_rdy), .alloc_s1_val(alloc_s1_val),
        .alloc_s2_rdy(alloc_s2_rdy), .alloc_s2_val(alloc_s2_val),
        .alloc_dst(alloc_dst), .alloc_dst_en(alloc_dst_en),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data), .bc_cause(bc_cause),
        .commit_valid(commit_valid), .commit_dst(commit_dst),
        .commit_dst_en(commit_dst_en), .commit_data(commit_data),
        .flush_valid(flush_valid), .flush_cause(flush_cause)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic bcast(input logic v, input logic [TAG_W-1:0] t,
                         input logic [DATA_W-1:0] d, input logic [CAUSE_W-1:0] c);
        bc_valid = v; bc_tag = t; bc_data = d; bc_cause = c;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 alloc_ready", 32'(alloc_ready), 1);
        chk("R1 alloc_tag", 32'(alloc_tag), 0);
        chk("R1 disp_valid", 32'(disp_valid), 0);
        chk("R1 commit_valid", 32'(commit_valid), 0);
        chk("R1 flush_valid", 32'(flush_valid), 0);

        // table walk: fill the buffer
        for (int i = 0; i < 4; i++) begin
            alloc_valid  = 1'b1;
            alloc_dst_en = 1'b1;
            {alloc_op, alloc_s1_rdy, alloc_s1_val, alloc_s2_rdy, alloc_s2_val, alloc_dst}
                = ALLOC_TBL[i][ROW_W-1:2];
            #1;
            chk("R2 alloc_tag", 32'(alloc_tag), 32'(ALLOC_TBL[i][1:0]));
            chk("R2 alloc_ready", 32'(alloc_ready), 1);
            @(negedge clk);
        end

        // R3: full, extra allocation ignored
        alloc_op = 4'hF; alloc_s1_rdy = 1; alloc_s1_val = 16'h1234;
        alloc_s2_rdy = 1; alloc_s2_val = 16'h1234; alloc_dst = 5'd9;
        #1;
        chk("R3 alloc_ready when full", 32'(alloc_ready), 0);
        chk("R4 disp_valid", 32'(disp_valid), 1);
        chk("R5 oldest tag", 32'(disp_tag), 0);
        chk("R4 disp_op", 32'(disp_op), 1);
        chk("R4 disp_a", 32'(disp_a), 10);
        chk("R4 disp_b", 32'(disp_b), 20);
        disp_ready = 1'b1;
        @(negedge clk);
        alloc_valid = 1'b0;
        #1;
        chk("R5 next ready tag", 32'(disp_tag), 2);
        chk("R4 disp_a e2", 32'(disp_a), 7);
        chk("R4 disp_b e2", 32'(disp_b), 8);
        @(negedge clk);
        disp_ready = 1'b0;
        #1;
        chk("R4 no ready entry", 32'(disp_valid), 0);
        bcast(1, 2'd2, 16'd100, 4'd0);
        @(negedge clk);
        bcast(1, 2'd0, 16'd50, 4'd0);
        #1;
        chk("R8 younger done, no commit", 32'(commit_valid), 0);
        @(negedge clk);
        bcast(0, 2'd0, 16'd0, 4'd0);
        #1;
        chk("R9 commit_valid", 32'(commit_valid), 1);
        chk("R9 commit_dst", 32'(commit_dst), 1);
        chk("R9 commit_dst_en", 32'(commit_dst_en), 1);
        chk("R9 commit_data", 32'(commit_data), 50);
        chk("R6 woken tag", 32'(disp_tag), 1);
        chk("R6 woken operand", 32'(disp_a), 50);
        chk("R6 other operand", 32'(disp_b), 5);
        disp_ready = 1'b1;
        @(negedge clk);
        #1;
        chk("R8 in-order hold", 32'(commit_valid), 0);
        chk("R6 two sources woken a", 32'(disp_a), 100);
        chk("R6 two sources woken b", 32'(disp_b), 50);
        chk("R6 e3 tag", 32'(disp_tag), 3);
        chk("R2 wrap tag", 32'(alloc_tag), 0);
        chk("R3 slot freed", 32'(alloc_ready), 1);
        // R7: allocation, broadcast and dispatch in one cycle
        alloc_valid = 1; alloc_op = 4'd5; alloc_s1_rdy = 0; alloc_s1_val = 16'd1;
        alloc_s2_rdy = 1; alloc_s2_val = 16'd9; alloc_dst = 5'd5;
        bcast(1, 2'd1, 16'd60, 4'd0);
        @(negedge clk);
        alloc_valid = 0; disp_ready = 0;
        bcast(0, 2'd0, 16'd0, 4'd0);
        #1;
        chk("R9 commit e1 dst", 32'(commit_dst), 2);
        chk("R8 commit e1 data", 32'(commit_data), 60);
        chk("R7 same-cycle capture valid", 32'(disp_valid), 1);
        chk("R7 same-cycle capture tag", 32'(disp_tag), 0);
        chk("R7 same-cycle capture a", 32'(disp_a), 60);
        chk("R7 op", 32'(disp_op), 5);
        @(negedge clk);
        #1;
        chk("R9 commit e2 valid", 32'(commit_valid), 1);
        chk("R9 commit e2 data", 32'(commit_data), 100);
        @(negedge clk);
        #1;
        chk("R8 head issued", 32'(commit_valid), 0);
        bcast(1, 2'd3, 16'd77, 4'd5);
        @(negedge clk);
        bcast(0, 2'd0, 16'd0, 4'd0);
        #1;
        chk("R10 flush_valid", 32'(flush_valid), 1);
        chk("R10 flush_cause", 32'(flush_cause), 5);
        chk("R10 no commit", 32'(commit_valid), 0);
        chk("R10 alloc blocked", 32'(alloc_ready), 0);
        @(negedge clk);
        #1;
        chk("R10 flush over", 32'(flush_valid), 0);
        chk("R10 nothing dispatched", 32'(disp_valid), 0);
        chk("R10 alloc_ready", 32'(alloc_ready), 1);
        chk("R10 alloc_tag at fault", 32'(alloc_tag), 3);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule